// File: doc/BRIEF.md
# Serial Status Readback Transmitter

This block is the read-mode half of a three-wire, half-duplex serial slave port. The receiver handles the write path. When it captures a command word that asks for a readback, it pulses `rd_cmd` in the system-clock cycle in which the last command bit was sampled. The transmitter then takes over the shared data line. It latches the status byte, drives the line, and shifts the byte out, most significant bit first, on falling serial-clock edges. When the transfer is done, or when the host aborts it, the transmitter lets go of the line.

Serial clock edges arrive as single-cycle strobes that have already been synchronized to the system clock. The output enable is asserted only while the block owns the line, so the output data pin can be tied to the input data pin. While a readback is in progress, `busy` tells the receiver to ignore incoming bits. `wr_lock` keeps the port closed after any readback until the host has raised chip-select and then lowered it again.

Top module: `status_readback_tx`

## Requirements
- R1: After a synchronous reset, `sdo`, `sdo_oe`, `busy` and `wr_lock` are all 0. A reset in the middle of a transfer clears all four in the following cycle.
- R2: A readback starts when `rd_cmd` is 1, `cs_n` is 0 and `wr_lock` is 0 while the block is idle. One cycle later `sdo_oe`, `busy` and `wr_lock` are 1 and `sdo` drives 0.
- R3: `rd_cmd` is ignored, leaving `busy` and `sdo_oe` at 0, when `cs_n` is 1 or when `wr_lock` is 1.
- R4: The status byte is captured in the start cycle. Later changes on `status_in` do not alter the bits sent.
- R5: On the k-th `sclk_fall` strobe of a transfer (k = 1..8), `sdo` takes bit 8-k of the captured byte one cycle later, so the MSB goes first. `sdo` does not change on any other cycle while driving.
- R6: In the cycle after the 8th `sclk_rise` strobe of the transfer, `sdo_oe` and `busy` fall to 0.
- R7: If `cs_n` is 1 while `busy` is 1, the transfer is aborted and `sdo_oe` and `busy` are 0 one cycle later.
- R8: `wr_lock` stays 1 while `cs_n` stays 0 after a readback. It becomes 0 in the cycle after `cs_n` is sampled at 1.
- R9: `sdo_oe` and `busy` are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk_rise | input | 1 | One-cycle strobe for a rising serial clock edge |
| sclk_fall | input | 1 | One-cycle strobe for a falling serial clock edge |
| rd_cmd | input | 1 | Receiver has captured a readback command |
| status_in | input | DATA_W | Status byte to be returned |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the shared data line |
| busy | output | 1 | Readback in progress; receiver must ignore bits |
| wr_lock | output | 1 | Port closed until chip-select toggles |

## Verification
The checker monitors several rules on every cycle:
- the enable and busy flags agree;
- a chip-select rise ends a transfer;
- `sdo` only moves on a falling strobe;
- a lock holds while chip-select stays low;
- a start is refused when chip-select is high or the lock is set;
- release follows the eighth rising strobe.

Some behaviour can only be shown by the bench's scenarios. These are the exact bit order for several byte values, isolation from `status_in` changes during shifting, aborts after different numbers of bits, and the full close-and-reopen sequence needed before a second readback.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [0:0] {
    RB_IDLE = 1'b0,
    RB_SEND = 1'b1
  } rb_state_e;
endpackage

// File: rtl/rb_bitcount.sv
module rb_bitcount #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(N - 1));
endmodule

// File: rtl/rb_shifter.sv
module rb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         drop,
  input  logic [W-1:0] din,
  output logic         sdo,
  output logic         oe
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      sdo <= 1'b0;
      oe  <= 1'b0;
    end else if (load) begin
      sh  <= din;
      sdo <= 1'b0;
      oe  <= 1'b1;
    end else if (drop) begin
      oe  <= 1'b0;
    end else if (shift) begin
      sdo <= sh[W-1];
      sh  <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/rb_lock.sv
module rb_lock (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic cs_n,
  output logic lock
);
  always_ff @(posedge clk) begin
    if (rst)       lock <= 1'b0;
    else if (cs_n) lock <= 1'b0;
    else if (set)  lock <= 1'b1;
  end
endmodule

// File: rtl/status_readback_tx.sv
module status_readback_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              rd_cmd,
  input  logic [DATA_W-1:0] status_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              wr_lock
);
  import rb_pkg::*;

  rb_state_e state;
  logic start, sending, fin, drop, shift, last;

  assign sending = (state == RB_SEND);
  assign start   = !sending && rd_cmd && !cs_n && !wr_lock;
  assign fin     = sending && sclk_rise && last;
  assign drop    = sending && (cs_n || fin);
  assign shift   = sending && sclk_fall && !cs_n;

  always_ff @(posedge clk) begin
    if (rst)        state <= RB_IDLE;
    else if (start) state <= RB_SEND;
    else if (drop)  state <= RB_IDLE;
  end

  assign busy = sending;

  rb_bitcount #(.N(DATA_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc (sending && sclk_rise),
    .last(last)
  );

  rb_shifter #(.W(DATA_W)) u_sh (
    .clk  (clk),
    .rst  (rst),
    .load (start),
    .shift(shift),
    .drop (drop),
    .din  (status_in),
    .sdo  (sdo),
    .oe   (sdo_oe)
  );

  rb_lock u_lock (
    .clk (clk),
    .rst (rst),
    .set (start),
    .cs_n(cs_n),
    .lock(wr_lock)
  );
endmodule

// File: rtl/status_readback_tx_chk.sv
module status_readback_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic rd_cmd,
  input logic sdo,
  input logic sdo_oe,
  input logic busy,
  input logic wr_lock
);
  localparam int CW = $clog2(DATA_W + 1);
  logic [CW-1:0] rises;

  always_ff @(posedge clk) begin
    if (rst || !busy)     rises <= '0;
    else if (sclk_rise)   rises <= rises + 1'b1;
  end

  // R9
  oe_busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe == busy);

  // R7
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_n) |=> (!sdo_oe && !busy));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && !sclk_fall) |=> $stable(sdo));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && !cs_n) |=> wr_lock);

  // R3
  no_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (cs_n || wr_lock)) |=> !busy);

  // R2
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_lock && !cs_n && rd_cmd) |=> (busy && sdo_oe && wr_lock && !sdo));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cs_n && sclk_rise && rises == CW'(DATA_W - 1)) |=> !busy);
endmodule

bind status_readback_tx status_readback_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .rd_cmd   (rd_cmd),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .busy     (busy),
  .wr_lock  (wr_lock)
);

// File: tb/sim_status_readback_tx.sv
module sim_status_readback_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk_rise = 1'b0;
  logic sclk_fall = 1'b0;
  logic rd_cmd = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic sdo, sdo_oe, busy, wr_lock;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  status_readback_tx #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .rd_cmd(rd_cmd), .status_in(status_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .wr_lock(wr_lock)
  );

  // {status byte, bits sent before chip-select rises (8 = complete)}
  localparam logic [11:0] VEC [6] = '{
    {8'hA5, 4'd8}, {8'h3C, 4'd8}, {8'h80, 4'd8},
    {8'h01, 4'd3}, {8'hFF, 4'd0}, {8'h5A, 4'd7}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_rise();
    @(negedge clk) sclk_rise = 1'b1;
    @(negedge clk) sclk_rise = 1'b0;
  endtask

  task automatic pulse_fall();
    @(negedge clk) sclk_fall = 1'b1;
    @(negedge clk) sclk_fall = 1'b0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk) rd_cmd = 1'b1;
    @(negedge clk) rd_cmd = 1'b0;
  endtask

  task automatic close_cs();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {7'd0, sdo_oe}, 8'd0);
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 lock", {7'd0, wr_lock}, 8'd0);
    check("R1 sdo", {7'd0, sdo}, 8'd0);

    // R3: command with chip-select high is ignored
    pulse_cmd();
    check("R3 cs high", {6'd0, busy, sdo_oe}, 8'd0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] st;
      int n;
      st = VEC[v][11:4];
      n  = int'(VEC[v][3:0]);
      @(negedge clk) begin cs_n = 1'b0; status_in = st; end
      pulse_cmd();
      // R2 entry
      check("R2 entry", {4'd0, sdo, wr_lock, busy, sdo_oe}, 8'b0000_0111);
      // R4 change input after capture
      status_in = ~st;
      for (int k = 0; k < n; k++) begin
        pulse_fall();
        // R5 MSB-first bit
        check("R5 bit", {7'd0, sdo}, {7'd0, st[7-k]});
        pulse_rise();
        check("R5 hold", {7'd0, sdo}, {7'd0, st[7-k]});
        if (k == 7) check("R6 release", {6'd0, busy, sdo_oe}, 8'd0);
        else        check("R6 still driving", {7'd0, sdo_oe}, 8'd1);
      end
      if (n == 8) begin
        // R8 lock holds, R3 new command refused
        check("R8 lock held", {7'd0, wr_lock}, 8'd1);
        pulse_cmd();
        check("R3 locked", {6'd0, busy, sdo_oe}, 8'd0);
        close_cs();
        check("R8 lock cleared", {7'd0, wr_lock}, 8'd0);
      end else begin
        close_cs();
        // R7 abort
        check("R7 abort", {6'd0, busy, sdo_oe}, 8'd0);
        check("R8 lock cleared", {7'd0, wr_lock}, 8'd0);
      end
    end

    // R1 reset mid-transfer
    @(negedge clk) begin cs_n = 1'b0; status_in = 8'hC3; end
    pulse_cmd();
    pulse_fall();
    check("R4 bit after change", {7'd0, sdo}, 8'd1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 mid reset", {4'd0, sdo, wr_lock, busy, sdo_oe}, 8'd0);

    // R2 reopen after reset with chip-select still low
    pulse_cmd();
    check("R2 reentry", {5'd0, wr_lock, busy, sdo_oe}, 8'b0000_0111);
    close_cs();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule